// File: doc/BRIEF.md
# Three-Wire Serial Slave Port

This block is the slave end of a three-wire serial link: a chip-enable input, a serial clock input and one bidirectional data line. The block does not clock itself from the serial clock. It passes all three pins through synchronizers into a fast system clock and detects the serial clock edges there. Each access opens with a command byte. The command picks the direction, one of two address spaces (clock or RAM) and a byte address. After the command comes one data byte or a run of consecutive bytes.

Writes leave the block as single-cycle strobes on a register-bank port, carrying space, address and data. Reads go out as single-cycle requests on the same port. The bank returns the byte one system clock later, and the block shifts it out on the data line under its own output-enable. The register contents, any write protection and all timekeeping live in the bank, not here.

Top module: `tws_slave`

## Requirements
- R1: Command bits arrive LSB first. Bit 0 = 1 means read and 0 means write. Bit 6 = 1 selects the RAM space and 0 selects the clock space. Bits 5:1 hold the address, and `space_o`/`addr_o` carry these with each strobe.
- R2: Write data bits are sampled on serial-clock rising edges, LSB first. After the eighth data bit, `wr_en_o` pulses for one system clock with `wr_data_o`, `addr_o` and `space_o` valid.
- R3: A write command whose bit 7 is 0 produces no `wr_en_o` pulse.
- R4: In a single-byte write, serial clocks after the sixteenth produce no further write.
- R5: `rd_req_o` pulses with the decoded address when the eighth command bit of a read is taken. Read bits are then driven LSB first on falling edges, and the first bit goes out on the falling edge right after the eighth command bit.
- R6: `dio_oe` is low after every serial rising edge and whenever chip-enable is low. It is high only in the read phase, after a falling edge.
- R7: Chip-enable going low abandons any partial transfer. The next command is decoded from its first bit.
- R8: Address 31 selects a burst that starts at address 0 and steps up by one per byte. A burst write stops after 8 bytes in the clock space and after 31 bytes in the RAM space.
- R9: A burst read requests the next address after each byte and wraps to 0 past its limit (8 clock, 31 RAM). Extra clocks in a single read resend the same address.
- R10: `rd_data_i` is taken one system clock after `rd_req_o`. `dio_oe` falls within 4 system clocks of chip-enable going low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip-enable pin, asynchronous |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| dio_i | input | 1 | Data line as seen at the pad |
| dio_o | output | 1 | Data line drive value |
| dio_oe | output | 1 | Data line drive enable |
| wr_en_o | output | 1 | One-cycle write strobe to the bank |
| rd_req_o | output | 1 | One-cycle read request to the bank |
| space_o | output | 1 | 0 clock space, 1 RAM space |
| addr_o | output | 5 | Byte address for strobe or request |
| wr_data_o | output | 8 | Write byte |
| rd_data_i | input | 8 | Read byte, valid one clock after the request |

## Verification
If the bit counter drifts, every later byte comes out rotated or lands at the wrong address. That shows up on the first strobe or read byte after the drift, and it persists until chip-enable drops. A burst counter that misses its limit shows up as an extra or missing write strobe, or as a wrong byte after the eighth or thirty-first read byte. Enable faults show up within one serial half period, because the drive flag is sampled in every half period of every transfer.

// File: rtl/tws_pkg.sv
package tws_pkg;
   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_WR   = 2'd1,
      PH_RD   = 2'd2,
      PH_DONE = 2'd3
   } phase_t;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] level_o
);
   localparam int CHAIN_W = WIDTH * STAGES;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tws_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("tws_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], async_i};
   end

   assign level_o = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
   import tws_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int CLK_LEN = 8,
   parameter int RAM_LEN = 31
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ce,
   input  logic                rise,
   input  logic                fall,
   input  logic                din,
   output phase_t              phase_o,
   output logic                wr_en_o,
   output logic                rd_req_o,
   output logic                space_o,
   output logic [DATA_W-4:0]   addr_o,
   output logic [DATA_W-1:0]   wr_data_o
);
   localparam int ADDR_W = DATA_W - 3;
   localparam int BIT_W  = $clog2(DATA_W);
   localparam int ADDR_N = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] CLK_LAST = ADDR_W'(CLK_LEN - 1);
   localparam logic [ADDR_W-1:0] RAM_LAST = ADDR_W'(RAM_LEN - 1);
   localparam logic [BIT_W-1:0]  BIT_LAST = BIT_W'(DATA_W - 1);

   generate
      if (DATA_W < 4) begin : g_bad_data
         $error("tws_ctrl: DATA_W too small for command layout");
      end
      if (CLK_LEN < 1 || CLK_LEN > ADDR_N - 1) begin : g_bad_clk
         $error("tws_ctrl: CLK_LEN out of range");
      end
      if (RAM_LEN < 1 || RAM_LEN > ADDR_N - 1) begin : g_bad_ram
         $error("tws_ctrl: RAM_LEN out of range");
      end
   endgenerate

   phase_t              phase_q;
   logic [DATA_W-1:0]   sh_q;
   logic [BIT_W-1:0]    bit_q;
   logic                en_q;
   logic                space_q;
   logic                burst_q;
   logic [ADDR_W-1:0]   addr_q;
   logic                wr_en_q;
   logic                rd_req_q;
   logic                out_space_q;
   logic [ADDR_W-1:0]   out_addr_q;
   logic [DATA_W-1:0]   wr_data_q;

   logic [DATA_W-1:0]   sh_next;
   logic                last_bit;
   logic [ADDR_W-1:0]   last_addr;
   logic [ADDR_W-1:0]   cmd_addr;
   logic                cmd_burst;
   logic [ADDR_W-1:0]   step_addr;

   always_comb begin
      sh_next   = {din, sh_q[DATA_W-1:1]};
      last_bit  = (bit_q == BIT_LAST);
      last_addr = space_q ? RAM_LAST : CLK_LAST;
      cmd_addr  = sh_next[ADDR_W:1];
      cmd_burst = &cmd_addr;
      step_addr = (addr_q == last_addr) ? '0 : addr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_CMD;
         sh_q        <= '0;
         bit_q       <= '0;
         en_q        <= 1'b0;
         space_q     <= 1'b0;
         burst_q     <= 1'b0;
         addr_q      <= '0;
         wr_en_q     <= 1'b0;
         rd_req_q    <= 1'b0;
         out_space_q <= 1'b0;
         out_addr_q  <= '0;
         wr_data_q   <= '0;
      end else begin
         wr_en_q  <= 1'b0;
         rd_req_q <= 1'b0;
         if (!ce) begin
            phase_q <= PH_CMD;
            bit_q   <= '0;
         end else begin
            unique case (phase_q)
               PH_CMD: begin
                  if (rise) begin
                     sh_q  <= sh_next;
                     bit_q <= last_bit ? '0 : bit_q + 1'b1;
                     if (last_bit) begin
                        en_q        <= sh_next[DATA_W-1];
                        space_q     <= sh_next[DATA_W-2];
                        burst_q     <= cmd_burst;
                        addr_q      <= cmd_burst ? '0 : cmd_addr;
                        out_space_q <= sh_next[DATA_W-2];
                        out_addr_q  <= cmd_burst ? '0 : cmd_addr;
                        if (sh_next[0]) begin
                           phase_q  <= PH_RD;
                           rd_req_q <= 1'b1;
                        end else begin
                           phase_q  <= PH_WR;
                        end
                     end
                  end
               end
               PH_WR: begin
                  if (rise) begin
                     sh_q  <= sh_next;
                     bit_q <= last_bit ? '0 : bit_q + 1'b1;
                     if (last_bit) begin
                        wr_en_q     <= en_q;
                        wr_data_q   <= sh_next;
                        out_addr_q  <= addr_q;
                        out_space_q <= space_q;
                        if (!burst_q || addr_q == last_addr) phase_q <= PH_DONE;
                        else addr_q <= addr_q + 1'b1;
                     end
                  end
               end
               PH_RD: begin
                  if (fall) begin
                     bit_q <= last_bit ? '0 : bit_q + 1'b1;
                     if (last_bit) begin
                        rd_req_q <= 1'b1;
                        if (burst_q) begin
                           addr_q     <= step_addr;
                           out_addr_q <= step_addr;
                        end
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign phase_o   = phase_q;
   assign wr_en_o   = wr_en_q;
   assign rd_req_o  = rd_req_q;
   assign space_o   = out_space_q;
   assign addr_o    = out_addr_q;
   assign wr_data_o = wr_data_q;

   AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_q |=> !wr_en_q); // R2
   AST_RD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_q |-> (phase_q == PH_RD)); // R5
   AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_q && phase_q != PH_CMD) |-> (addr_q <= last_addr)); // R8
   AST_NO_WR_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_RD) |=> !wr_en_q); // R1
endmodule

// File: rtl/tws_tx.sv
module tws_tx #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              rise,
   input  logic              fall,
   input  logic              rd_phase,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   output logic              dout_o,
   output logic              oe_o
);
   logic [DATA_W-1:0] sh_q;
   logic              dout_q;
   logic              oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         dout_q <= 1'b0;
         oe_q   <= 1'b0;
      end else begin
         if (load)                         sh_q <= load_data;
         else if (ce && fall && rd_phase)  sh_q <= sh_q >> 1;

         if (!ce || rise) begin
            oe_q <= 1'b0;
         end else if (fall && rd_phase) begin
            oe_q   <= 1'b1;
            dout_q <= sh_q[0];
         end
      end
   end

   assign dout_o = dout_q;
   assign oe_o   = oe_q;

   AST_OE_CE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> !oe_q); // R6
   AST_OE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !oe_q); // R6
endmodule

// File: rtl/tws_slave.sv
module tws_slave
   import tws_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CLK_LEN     = 8,
   parameter int RAM_LEN     = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_i,
   input  logic              sclk_i,
   input  logic              dio_i,
   output logic              dio_o,
   output logic              dio_oe,
   output logic              wr_en_o,
   output logic              rd_req_o,
   output logic              space_o,
   output logic [DATA_W-4:0] addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   input  logic [DATA_W-1:0] rd_data_i
);
   localparam int PIN_N = 3;

   logic [PIN_N-1:0] pins_s;
   logic             ce_s, sclk_s, din_s;
   logic             sclk_prev_q;
   logic             sclk_rise, sclk_fall;
   logic             rd_vld_q;
   phase_t           phase;

   tws_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({ce_i, sclk_i, dio_i}),
      .level_o (pins_s)
   );

   assign {ce_s, sclk_s, din_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev_q <= 1'b0;
         rd_vld_q    <= 1'b0;
      end else begin
         sclk_prev_q <= sclk_s;
         rd_vld_q    <= rd_req_o;
      end
   end

   assign sclk_rise = ce_s &  sclk_s & ~sclk_prev_q;
   assign sclk_fall = ce_s & ~sclk_s &  sclk_prev_q;

   tws_ctrl #(.DATA_W(DATA_W), .CLK_LEN(CLK_LEN), .RAM_LEN(RAM_LEN)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce        (ce_s),
      .rise      (sclk_rise),
      .fall      (sclk_fall),
      .din       (din_s),
      .phase_o   (phase),
      .wr_en_o   (wr_en_o),
      .rd_req_o  (rd_req_o),
      .space_o   (space_o),
      .addr_o    (addr_o),
      .wr_data_o (wr_data_o)
   );

   tws_tx #(.DATA_W(DATA_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce        (ce_s),
      .rise      (sclk_rise),
      .fall      (sclk_fall),
      .rd_phase  (phase == PH_RD),
      .load      (rd_vld_q),
      .load_data (rd_data_i),
      .dout_o    (dio_o),
      .oe_o      (dio_oe)
   );

   AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      dio_oe |-> (phase == PH_RD)); // R6
   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_o && rd_req_o)); // R1
endmodule

// File: tb/tb_tws_slave.sv
module tb_tws_slave;
   localparam int HP = 10;

   logic clk = 1'b0;
   logic rst_n, ce_i, sclk_i, dio_i;
   logic dio_o, dio_oe, wr_en_o, rd_req_o, space_o;
   logic [4:0] addr_o;
   logic [7:0] wr_data_o, rd_data_i;

   int n_chk = 0, n_fail = 0;
   int wn = 0, rn = 0;
   logic [4:0] wl_addr [128];
   logic       wl_space [128];
   logic [7:0] wl_data [128];
   logic [4:0] last_rd_addr;
   logic       last_rd_space;

   always #10 clk = ~clk;

   tws_slave dut (
      .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .sclk_i(sclk_i), .dio_i(dio_i),
      .dio_o(dio_o), .dio_oe(dio_oe), .wr_en_o(wr_en_o), .rd_req_o(rd_req_o),
      .space_o(space_o), .addr_o(addr_o), .wr_data_o(wr_data_o),
      .rd_data_i(rd_data_i)
   );

   function automatic logic [7:0] mem_val(input logic s, input logic [4:0] a);
      return 8'((int'(a) * 37 + int'(s) * 101 + 5) & 8'hFF);
   endfunction

   function automatic logic [7:0] mk_cmd(input logic en, input logic s,
                                         input logic [4:0] a, input logic rd);
      return {en, s, a, rd};
   endfunction

   always @(posedge clk) begin
      if (rd_req_o) begin
         rd_data_i     <= mem_val(space_o, addr_o);
         last_rd_addr  <= addr_o;
         last_rd_space <= space_o;
         rn++;
      end
      if (wr_en_o && wn < 128) begin
         wl_addr[wn]  = addr_o;
         wl_space[wn] = space_o;
         wl_data[wn]  = wr_data_o;
         wn++;
      end
   end

   task automatic check(input logic ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic xfer_bits(input logic [7:0] din, input int nb, input logic is_rd,
                            output logic [7:0] dout, output int oe_bad);
      dout = '0;
      oe_bad = 0;
      for (int i = 0; i < nb; i++) begin
         dio_i = din[i];
         repeat (HP) @(negedge clk);
         dout[i] = dio_o;
         if (dio_oe !== is_rd) oe_bad++;
         sclk_i = 1'b1;
         repeat (HP) @(negedge clk);
         if (dio_oe !== 1'b0) oe_bad++;
         sclk_i = 1'b0;
      end
   endtask

   task automatic start_x();
      sclk_i = 1'b0;
      ce_i = 1'b1;
   endtask

   task automatic stop_x();
      ce_i = 1'b0;
      sclk_i = 1'b0;
      repeat (HP) @(negedge clk);
   endtask

   task automatic single_write(input logic s, input logic [4:0] a,
                               input logic [7:0] d, input int extra, input logic en);
      logic [7:0] dd;
      int ob;
      int w0;
      w0 = wn;
      start_x();
      xfer_bits(mk_cmd(en, s, a, 1'b0), 8, 1'b0, dd, ob);
      xfer_bits(d, 8, 1'b0, dd, ob);
      repeat (6) @(negedge clk);
      if (en) begin
         check(wn == w0 + 1, "R2", "write count", wn - w0, 1);
         check(wl_addr[w0] == a && wl_space[w0] == s, "R1", "write address/space",
               int'({wl_space[w0], wl_addr[w0]}), int'({s, a}));
         check(wl_data[w0] == d, "R2", "write data", wl_data[w0], d);
      end else begin
         check(wn == w0, "R3", "disabled write count", wn - w0, 0);
      end
      if (extra > 0) begin
         xfer_bits(8'hFF, extra, 1'b0, dd, ob);
         repeat (6) @(negedge clk);
         check(wn == w0 + (en ? 1 : 0), "R4", "writes after extra clocks",
               wn - w0, en ? 1 : 0);
      end
      stop_x();
   endtask

   task automatic single_read(input logic s, input logic [4:0] a, input int nbytes);
      logic [7:0] dd;
      int ob;
      start_x();
      xfer_bits(mk_cmd(1'b1, s, a, 1'b1), 8, 1'b0, dd, ob);
      check(ob == 0, "R6", "enable during command", ob, 0);
      check(last_rd_addr == a && last_rd_space == s, "R5", "read request address",
            int'({last_rd_space, last_rd_addr}), int'({s, a}));
      for (int b = 0; b < nbytes; b++) begin
         xfer_bits(8'h00, 8, 1'b1, dd, ob);
         // R10: byte fetched one clock after request
         if (b == 0) check(dd == mem_val(s, a), "R5", "read byte", dd, mem_val(s, a));
         else        check(dd == mem_val(s, a), "R9", "resent byte", dd, mem_val(s, a));
         check(ob == 0, "R6", "enable pattern in read", ob, 0);
      end
      stop_x();
   endtask

   initial begin
      logic [7:0] dd;
      int ob, w0, n;
      void'($urandom(32'h5EED_1302));
      rst_n = 1'b0; ce_i = 1'b0; sclk_i = 1'b0; dio_i = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      check(dio_oe == 1'b0 && wr_en_o == 1'b0 && rd_req_o == 1'b0, "R6",
            "reset outputs", int'({dio_oe, wr_en_o, rd_req_o}), 0);

      single_write(1'b0, 5'd3, 8'hA5, 8, 1'b1);     // R1 R2 R4
      single_write(1'b1, 5'd17, 8'h5A, 0, 1'b0);    // R3
      single_read(1'b1, 5'd5, 2);                   // R5 R9

      // R7: partial command abandoned
      start_x();
      xfer_bits(mk_cmd(1'b1, 1'b1, 5'd9, 1'b1), 5, 1'b0, dd, ob);
      stop_x();
      single_write(1'b1, 5'd7, 8'h3C, 0, 1'b1);
      check(wl_addr[wn-1] == 5'd7, "R7", "address after abort", wl_addr[wn-1], 7);

      // R10: enable release latency after chip-enable drop mid-read
      start_x();
      xfer_bits(mk_cmd(1'b1, 1'b0, 5'd2, 1'b1), 8, 1'b0, dd, ob);
      xfer_bits(8'h00, 3, 1'b1, dd, ob);
      dio_i = 1'b0;
      repeat (HP) @(negedge clk);
      check(dio_oe == 1'b1, "R6", "driving in read low half", dio_oe, 1);
      ce_i = 1'b0;
      repeat (4) @(negedge clk);
      check(dio_oe == 1'b0, "R10", "enable after chip-enable low", dio_oe, 0);
      stop_x();

      // R8: clock-space burst write, 10 bytes offered
      w0 = wn;
      start_x();
      xfer_bits(mk_cmd(1'b1, 1'b0, 5'd31, 1'b0), 8, 1'b0, dd, ob);
      for (int b = 0; b < 10; b++) xfer_bits(8'(8'h40 + b), 8, 1'b0, dd, ob);
      stop_x();
      check(wn - w0 == 8, "R8", "clock burst count", wn - w0, 8);
      for (int b = 0; b < 8; b++)
         check(wl_addr[w0+b] == 5'(b) && wl_data[w0+b] == 8'(8'h40 + b) && !wl_space[w0+b],
               "R8", "clock burst entry", int'(wl_addr[w0+b]), b);

      // R8: RAM burst, 33 bytes offered then random shorter run
      for (int pass = 0; pass < 2; pass++) begin
         n = (pass == 0) ? 33 : int'($urandom_range(1, 30));
         w0 = wn;
         start_x();
         xfer_bits(mk_cmd(1'b1, 1'b1, 5'd31, 1'b0), 8, 1'b0, dd, ob);
         for (int b = 0; b < n; b++) xfer_bits(8'(b * 7 + 1), 8, 1'b0, dd, ob);
         stop_x();
         check(wn - w0 == ((n > 31) ? 31 : n), "R8", "RAM burst count", wn - w0,
               (n > 31) ? 31 : n);
         for (int b = 0; b < ((n > 31) ? 31 : n); b++)
            check(wl_addr[w0+b] == 5'(b) && wl_data[w0+b] == 8'(b * 7 + 1) && wl_space[w0+b],
                  "R8", "RAM burst entry", int'(wl_data[w0+b]), (b * 7 + 1) & 255);
      end

      // R9: clock burst read wraps after 8 bytes
      start_x();
      xfer_bits(mk_cmd(1'b1, 1'b0, 5'd31, 1'b1), 8, 1'b0, dd, ob);
      for (int b = 0; b < 10; b++) begin
         xfer_bits(8'h00, 8, 1'b1, dd, ob);
         check(dd == mem_val(1'b0, 5'(b % 8)), "R9", "clock burst read byte", dd,
               mem_val(1'b0, 5'(b % 8)));
      end
      stop_x();

      // R9: RAM burst read increments
      start_x();
      xfer_bits(mk_cmd(1'b1, 1'b1, 5'd31, 1'b1), 8, 1'b0, dd, ob);
      for (int b = 0; b < 4; b++) begin
         xfer_bits(8'h00, 8, 1'b1, dd, ob);
         check(dd == mem_val(1'b1, 5'(b)), "R9", "RAM burst read byte", dd,
               mem_val(1'b1, 5'(b)));
      end
      stop_x();

      // random single accesses (R1 R2 R5)
      for (int k = 0; k < 30; k++) begin
         logic s;
         logic [4:0] a;
         s = 1'($urandom_range(0, 1));
         a = 5'($urandom_range(0, 30));
         if ($urandom_range(0, 1) == 1) single_read(s, a, 1);
         else single_write(s, a, 8'($urandom), 0, 1'b1);
      end

      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog expired: actual=%0d expected=%0d", 150000, 0);
      summary();
      $finish;
   end
endmodule